// File: doc/BRIEF.md
# Read-Gate Preamble Lock Sequencer

This block sequences the acquisition modes of a disk read-channel data synchronizer. It takes the read gate, an active-low frequency-lock enable and a hold request, all of which may change at any moment. It also takes a stream of qualified read pulses that are already in the sampling-clock domain. From these inputs it decides whether the phase-locked loop is frequency-locking to the preamble or tracking random data with pulse gating. It also runs a fixed zero-phase-start phase at the start of every read. After that phase it measures the spacing between read pulses in sampling-clock cycles.

When enough consecutive pulses arrive at the expected 2T or 3T preamble spacing, the block raises a preamble-detected flag. The flag stays latched for the rest of the read. A coast output tells the loop to stop phase comparison while hold is asserted during a read. The block has no analog function: it only produces the mode controls that the oscillator, charge pump and loop filter act on.

Top module: `rg_preamble_seq`

## Requirements
- R1: While the synchronized read gate is low, `flock_mode` is 1 and `track_mode` is 0, whatever the level of `flock_en_n`.
- R2: When a read starts with `flock_en_n` low, `flock_mode` stays 1 and `track_mode` stays 0.
- R3: Once `flock_en_n` is high during a read, `flock_mode` drops to 0 and `track_mode` rises to 1. They keep those values until the read gate falls, even if `flock_en_n` returns low. A read that starts with `flock_en_n` high tracks from the start.
- R4: Every rising edge of the synchronized read gate starts a zero-phase-start phase. During it `zps_active` is high for exactly ZPS_CYCLES (default 8) clock cycles, and `zps_done` pulses for one cycle as the phase ends.
- R5: The expected spacing is E = 2·`cfg_t_cycles` when `cfg_pat3t` is 0 and E = 3·`cfg_t_cycles` when `cfg_pat3t` is 1. A pulse interval of I cycles qualifies only if 4·I ≥ 3·E and 4·I ≤ 5·E, which is E within ±25 %.
- R6: Pulse intervals are counted only after the zero-phase-start phase, and the first pulse after it only sets the reference. `preamble_det` rises once RUN_THRESH (default 16) consecutive qualifying intervals have been seen. One interval fewer leaves it low.
- R7: An interval that does not qualify clears the consecutive count to zero.
- R8: Once `preamble_det` is high it stays high for the rest of the read, even after intervals that do not qualify. It goes low when the read gate falls and is never high outside a read.
- R9: `coast` is 1 while `hold` is high during a read and 0 otherwise. A hold outside a read has no effect.
- R10: After reset, `flock_mode` is 1 and `track_mode`, `zps_active`, `zps_done`, `coast` and `preamble_det` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| read_gate | input | 1 | Read mode request, asynchronous |
| flock_en_n | input | 1 | Frequency-lock enable, active low, asynchronous |
| hold | input | 1 | Coast request, asynchronous |
| rd_pulse | input | 1 | Qualified read pulse, one-cycle strobe in the clk domain |
| cfg_pat3t | input | 1 | Preamble pattern: 0 selects 2T, 1 selects 3T |
| cfg_t_cycles | input | TW (6) | Sampling cycles per code period T |
| flock_mode | output | 1 | Loop is in frequency-lock mode |
| track_mode | output | 1 | Loop is in pulse-gated phase tracking |
| zps_active | output | 1 | Zero-phase-start phase in progress |
| zps_done | output | 1 | One-cycle strobe at the end of zero-phase start |
| coast | output | 1 | Suppress phase comparison |
| preamble_det | output | 1 | Latched preamble-detected flag |

## Verification
The run detector is driven with pulse trains at the exact 2T and 3T spacings and at both edges of the ±25 % window and just outside them. This separates correct window arithmetic from off-by-one errors and from a wrong pattern multiplier. Trains one interval short of the threshold and trains broken by a single long gap separate a true consecutive count from a plain total. The mode tests drive `flock_en_n` before, during and after a read. This shows whether frequency lock is forced, whether tracking is sticky, and whether hold is masked outside a read.

// File: rtl/rgps_pkg.sv
package rgps_pkg;

    // Acquisition phase of one read
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_ZPS  = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    // Synchronized control inputs
    typedef struct packed {
        logic rg;
        logic flc_n;
        logic hold;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Expected preamble spacing in sampling cycles
    function automatic int unsigned exp_spacing(int unsigned t_cyc, logic pat3t);
        return pat3t ? t_cyc * 3 : t_cyc * 2;
    endfunction

    // Interval within +/-25 % of the expected spacing
    function automatic logic gap_ok(int unsigned gap, int unsigned exp);
        return (gap * 4 >= exp * 3) && (gap * 4 <= exp * 5);
    endfunction

endpackage

// File: rtl/rgps_sync.sv
module rgps_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= rst_val;
        else     stage_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= rst_val;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rgps_zps_timer.sv
module rgps_zps_timer #(
    parameter int ZPS_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic active,
    output logic done
);
    localparam int ZW = $clog2(ZPS_CYCLES + 1);
    localparam logic [ZW-1:0] LOAD = ZW'(ZPS_CYCLES);

    logic [ZW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= LOAD;
            done_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
            done_q <= (cnt_q == ZW'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign active = (cnt_q != '0);
    assign done   = done_q;
endmodule

// File: rtl/rgps_run_detect.sv
module rgps_run_detect
    import rgps_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int TW         = 6,
    parameter int RUN_THRESH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_read,
    input  logic          enable,
    input  logic          pulse,
    input  logic          pat3t,
    input  logic [TW-1:0] t_cycles,
    output logic          det
);
    localparam int RW = $clog2(RUN_THRESH + 1);
    localparam logic [CNT_W-1:0] GAP_MAX = '1;
    localparam logic [RW-1:0]    RUN_TOP = RW'(RUN_THRESH);

    logic [CNT_W-1:0] gap_q;
    logic             have_ref_q;
    logic [RW-1:0]    run_q;
    logic             det_q;
    logic             qual;

    always_comb begin
        qual = gap_ok(32'(gap_q), exp_spacing(32'(t_cycles), pat3t));
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            gap_q      <= '0;
            have_ref_q <= 1'b0;
            run_q      <= '0;
        end else if (pulse) begin
            gap_q      <= CNT_W'(1);
            have_ref_q <= 1'b1;
            if (have_ref_q) begin
                if (!qual)                run_q <= '0;
                else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
            end
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !in_read)       det_q <= 1'b0;
        else if (run_q == RUN_TOP) det_q <= 1'b1;
    end

    assign det = det_q;
endmodule

// File: rtl/rg_preamble_seq.sv
module rg_preamble_seq
    import rgps_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ZPS_CYCLES  = 8,
    parameter int CNT_W       = 8,
    parameter int TW          = 6,
    parameter int RUN_THRESH  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          read_gate,
    input  logic          flock_en_n,
    input  logic          hold,
    input  logic          rd_pulse,
    input  logic          cfg_pat3t,
    input  logic [TW-1:0] cfg_t_cycles,
    output logic          flock_mode,
    output logic          track_mode,
    output logic          zps_active,
    output logic          zps_done,
    output logic          coast,
    output logic          preamble_det
);
    localparam ctl_t CTL_RST = '{rg: 1'b0, flc_n: 1'b0, hold: 1'b0};

    ctl_t   ctl_raw, ctl_s;
    logic   rg_s, hold_s, flc_n_s;
    phase_e phase_q;
    logic   zps_start, zps_act, zps_end;
    logic   flock_q, flock_nxt, track_q, coast_q;

    assign ctl_raw = '{rg: read_gate, flc_n: flock_en_n, hold: hold};

    rgps_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ctl_raw),
        .rst_val (CTL_RST),
        .q       (ctl_s)
    );

    assign rg_s    = ctl_s.rg;
    assign hold_s  = ctl_s.hold;
    assign flc_n_s = ctl_s.flc_n;

    assign zps_start = rg_s && (phase_q == PH_OFF);

    rgps_zps_timer #(.ZPS_CYCLES(ZPS_CYCLES)) u_zps (
        .clk    (clk),
        .rst    (rst),
        .start  (zps_start),
        .abort  (!rg_s),
        .active (zps_act),
        .done   (zps_end)
    );

    always_ff @(posedge clk) begin
        if (rst || !rg_s) begin
            phase_q <= PH_OFF;
        end else begin
            unique case (phase_q)
                PH_OFF:  phase_q <= PH_ZPS;
                PH_ZPS:  if (zps_end) phase_q <= PH_RUN;
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    rgps_run_detect #(
        .CNT_W      (CNT_W),
        .TW         (TW),
        .RUN_THRESH (RUN_THRESH)
    ) u_run (
        .clk      (clk),
        .rst      (rst),
        .in_read  (rg_s),
        .enable   (phase_q == PH_RUN),
        .pulse    (rd_pulse),
        .pat3t    (cfg_pat3t),
        .t_cycles (cfg_t_cycles),
        .det      (preamble_det)
    );

    // Frequency lock forced outside read; released for good once the enable goes high
    always_comb begin
        if (!rg_s)        flock_nxt = 1'b1;
        else if (flc_n_s) flock_nxt = 1'b0;
        else              flock_nxt = flock_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flock_q <= 1'b1;
            track_q <= 1'b0;
            coast_q <= 1'b0;
        end else begin
            flock_q <= flock_nxt;
            track_q <= rg_s && !flock_nxt;
            coast_q <= rg_s && hold_s;
        end
    end

    assign flock_mode = flock_q;
    assign track_mode = track_q;
    assign coast      = coast_q;
    assign zps_active = zps_act;
    assign zps_done   = zps_end;
endmodule

// File: rtl/rgps_checker.sv
module rgps_checker (
    input logic clk,
    input logic rst,
    input logic rg_s,
    input logic hold_s,
    input logic flock_mode,
    input logic zps_active,
    input logic zps_done,
    input logic coast,
    input logic preamble_det
);
    a_r1_flock_outside_read: assert property (@(posedge clk) disable iff (rst)
        !rg_s |=> flock_mode);

    a_r3_track_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(rg_s) && !$past(flock_mode)) |-> !flock_mode);

    a_r4_done_closes_zps: assert property (@(posedge clk) disable iff (rst)
        zps_done |-> !zps_active);

    a_r6_det_after_zps: assert property (@(posedge clk) disable iff (rst)
        $rose(preamble_det) |-> !zps_active);

    a_r8_det_latched: assert property (@(posedge clk) disable iff (rst)
        (preamble_det && rg_s) |=> preamble_det);

    a_r8_det_cleared: assert property (@(posedge clk) disable iff (rst)
        !rg_s |=> !preamble_det);

    a_r9_coast_on: assert property (@(posedge clk) disable iff (rst)
        (rg_s && hold_s) |=> coast);

    a_r9_coast_off: assert property (@(posedge clk) disable iff (rst)
        !(rg_s && hold_s) |=> !coast);
endmodule

bind rg_preamble_seq rgps_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .rg_s         (rg_s),
    .hold_s       (hold_s),
    .flock_mode   (flock_mode),
    .zps_active   (zps_active),
    .zps_done     (zps_done),
    .coast        (coast),
    .preamble_det (preamble_det)
);

// File: tb/tb_rg_preamble_seq.sv
module tb_rg_preamble_seq;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          read_gate = 1'b0;
    logic          flock_en_n = 1'b0;
    logic          hold = 1'b0;
    logic          rd_pulse = 1'b0;
    logic          cfg_pat3t = 1'b0;
    logic [TW-1:0] cfg_t_cycles = 6'd4;
    logic          flock_mode, track_mode, zps_active, zps_done, coast, preamble_det;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rg_preamble_seq dut (
        .clk(clk), .rst(rst), .read_gate(read_gate), .flock_en_n(flock_en_n),
        .hold(hold), .rd_pulse(rd_pulse), .cfg_pat3t(cfg_pat3t),
        .cfg_t_cycles(cfg_t_cycles), .flock_mode(flock_mode),
        .track_mode(track_mode), .zps_active(zps_active), .zps_done(zps_done),
        .coast(coast), .preamble_det(preamble_det)
    );

    typedef struct packed {
        logic       pat3t;
        logic [5:0] tcyc;
        logic [7:0] gap;
        logic [5:0] npulse;
        logic       det;
    } vec_t;

    // pulses = intervals + 1; det expected per R5/R6
    localparam vec_t VECS [10] = '{
        '{1'b0, 6'd4, 8'd8,  6'd17, 1'b1},  // 2T exact, 16 intervals
        '{1'b0, 6'd4, 8'd8,  6'd16, 1'b0},  // one interval short
        '{1'b1, 6'd4, 8'd12, 6'd17, 1'b1},  // 3T exact
        '{1'b1, 6'd4, 8'd8,  6'd17, 1'b0},  // 2T spacing with 3T selected
        '{1'b0, 6'd4, 8'd10, 6'd17, 1'b1},  // upper window edge
        '{1'b0, 6'd4, 8'd11, 6'd17, 1'b0},  // just above
        '{1'b0, 6'd4, 8'd6,  6'd17, 1'b1},  // lower window edge
        '{1'b0, 6'd4, 8'd5,  6'd17, 1'b0},  // just below
        '{1'b1, 6'd8, 8'd24, 6'd17, 1'b1},  // 3T, longer T
        '{1'b1, 6'd8, 8'd18, 6'd17, 1'b1}   // 3T lower edge (4*18=72=3*24)
    };

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_pulses(int n, int gap);
        for (int i = 0; i < n; i++) begin
            rd_pulse = 1'b1;
            @(negedge clk);
            rd_pulse = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic start_read();
        read_gate = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic end_read();
        read_gate = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int zcnt, dcnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 flock_mode", flock_mode, 1'b1);
        check("R10 track_mode", track_mode, 1'b0);
        check("R10 zps_active", zps_active, 1'b0);
        check("R10 zps_done", zps_done, 1'b0);
        check("R10 coast", coast, 1'b0);
        check("R10 preamble_det", preamble_det, 1'b0);

        // Table of pulse trains (R5, R6)
        for (int v = 0; v < 10; v++) begin
            cfg_pat3t    = VECS[v].pat3t;
            cfg_t_cycles = VECS[v].tcyc;
            start_read();
            send_pulses(int'(VECS[v].npulse), int'(VECS[v].gap));
            repeat (4) @(negedge clk);
            check($sformatf("R5/R6 vector %0d", v), preamble_det, VECS[v].det);
            end_read();
            check("R8 det low after read", preamble_det, 1'b0);
        end

        // R4 zero-phase-start length and done strobe
        cfg_pat3t = 1'b0; cfg_t_cycles = 6'd4;
        read_gate = 1'b1;
        zcnt = 0; dcnt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (zps_active) zcnt++;
            if (zps_done) dcnt++;
        end
        check_int("R4 zps_active cycles", zcnt, 8);
        check_int("R4 zps_done pulses", dcnt, 1);
        // R2 read began with flock enabled
        check("R2 flock held", flock_mode, 1'b1);
        check("R2 no tracking", track_mode, 1'b0);

        // R7 broken run, then completion
        send_pulses(11, 8);
        repeat (6) @(negedge clk);
        send_pulses(16, 8);
        check("R7 run cleared by long gap", preamble_det, 1'b0);
        send_pulses(1, 8);
        repeat (3) @(negedge clk);
        check("R7 run completes after restart", preamble_det, 1'b1);
        // R8 latch survives a bad interval
        repeat (30) @(negedge clk);
        send_pulses(1, 8);
        repeat (3) @(negedge clk);
        check("R8 det latched", preamble_det, 1'b1);

        // R3 switch to tracking and stickiness
        flock_en_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R3 flock released", flock_mode, 1'b0);
        check("R3 tracking", track_mode, 1'b1);
        flock_en_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R3 tracking sticky", flock_mode, 1'b0);

        // R9 coast in read
        hold = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 coast in read", coast, 1'b1);

        // R1 / R8 / R9 after read ends
        flock_en_n = 1'b1;
        end_read();
        check("R1 flock forced", flock_mode, 1'b1);
        check("R1 no tracking", track_mode, 1'b0);
        check("R8 det cleared", preamble_det, 1'b0);
        check("R9 hold ignored outside read", coast, 1'b0);
        hold = 1'b0;

        // R3 read starting with flock disabled
        start_read();
        check("R3 track from start", track_mode, 1'b1);
        check("R3 no flock from start", flock_mode, 1'b0);
        end_read();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule